// File: doc/BRIEF.md
# Sleep Instruction Power-Down Controller

This block decides what happens when the core executes a SLEEP instruction. It sees a one-cycle strobe for each SLEEP, a control bit that turns SLEEP into a synchronous exception, and a standby-select bit. It also sees a wake-capable interrupt line and a strobe for each return from an exception. From these inputs it takes one of three actions. It can enter a low-power state that stops the core clock. It can raise a sleep-instruction exception, which blocks power-down. Or, when a wake interrupt is already pending, it has that interrupt serviced first and runs the SLEEP again when the handler returns.

Exception requests leave the block as single-cycle pulses with a 1-bit cause code. A sticky flag reports the illegal setting in which the exception is enabled while standby is selected. The wake detector runs on the free-running clock, so the core clock enable can rise in the same cycle the wake edge is seen.

Top module: `sleep_pd_ctrl`

## Requirements
- R1: A synchronous active-high reset gives pwr_down=0, clk_en=1, exc_req=0 and cfg_err=0, and clears any pending replay.
- R2: A SLEEP strobe while running, with exc_en=0 and wake_irq low, sets pwr_down on the next cycle and raises no exception.
- R3: While powered down, a rising edge of wake_irq clears pwr_down on the next cycle and pulses exc_req on that cycle with exc_cause=0 (interrupt).
- R4: clk_en stays high in the first cycle of power-down and is low from the second cycle on. It goes high combinationally in the cycle a wake edge is present.
- R5: A SLEEP strobe with exc_en=1 pulses exc_req on the next cycle with exc_cause=1 (sleep instruction), whatever wake_irq is. pwr_down stays 0 then and afterwards.
- R6: A SLEEP strobe with exc_en=0 and wake_irq high pulses exc_req on the next cycle with exc_cause=0, without power-down. The next rte_stb then sets pwr_down on the following cycle.
- R7: After such a replayed SLEEP, a wake_irq level that was already high does not end power-down. Only a new rising edge ends it.
- R8: A SLEEP strobe with exc_en=1 and stby_sel=1 sets cfg_err, which stays set until reset. The sleep exception is still raised.
- R9: exc_req is high for exactly one cycle for each accepted event.
- R10: rte_stb has no effect on pwr_down when no SLEEP replay is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_stb | input | 1 | One-cycle strobe when SLEEP executes |
| exc_en | input | 1 | 1: SLEEP raises a sleep exception |
| stby_sel | input | 1 | Standby select; must be 0 when exc_en=1 |
| wake_irq | input | 1 | Wake-capable interrupt request level |
| rte_stb | input | 1 | One-cycle strobe on return from exception |
| pwr_down | output | 1 | Power-down state indication |
| clk_en | output | 1 | Core clock enable |
| exc_req | output | 1 | Single-cycle exception request pulse |
| exc_cause | output | 1 | Cause of the request: 0 interrupt, 1 sleep instruction |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The block's registered results (pwr_down, exc_req, exc_cause, cfg_err) change one clock edge after the strobe or wake edge that causes them. The bench drives each stimulus on a falling edge and reads those outputs at the next falling edge. clk_en depends on both pwr_down and a registered copy of it, so it falls one edge later than pwr_down. On a wake it rises with no edge at all, so the bench reads it 1 ns after driving wake_irq. The sweeps vary the number of cycles spent powered down, the standby bit and the level of the pending interrupt, and each expected value is derived from these delays.

// File: rtl/sleep_pd_ctrl.sv
module sleep_pd_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sleep_stb,
  input  logic exc_en,
  input  logic stby_sel,
  input  logic wake_irq,
  input  logic rte_stb,
  output logic pwr_down,
  output logic clk_en,
  output logic exc_req,
  output logic exc_cause,
  output logic cfg_err
);

  logic wake_q, gate_q, replay_q;

  wire running    = !pwr_down && !replay_q;
  wire take_sleep = running && sleep_stb;
  wire wake_edge  = pwr_down && wake_irq && !wake_q;

  assign clk_en = !(pwr_down && gate_q) || wake_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q    <= 1'b0;
      gate_q    <= 1'b0;
      replay_q  <= 1'b0;
      pwr_down  <= 1'b0;
      exc_req   <= 1'b0;
      exc_cause <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      wake_q  <= wake_irq;
      gate_q  <= pwr_down;
      exc_req <= 1'b0;
      if (take_sleep) begin
        if (exc_en) begin
          exc_req   <= 1'b1;
          exc_cause <= 1'b1;
          if (stby_sel) cfg_err <= 1'b1;
        end else if (wake_irq) begin
          exc_req   <= 1'b1;
          exc_cause <= 1'b0;
          replay_q  <= 1'b1;
        end else begin
          pwr_down <= 1'b1;
        end
      end else if (replay_q && rte_stb) begin
        replay_q <= 1'b0;
        pwr_down <= 1'b1;
      end else if (wake_edge) begin
        pwr_down  <= 1'b0;
        exc_req   <= 1'b1;
        exc_cause <= 1'b0;
      end
    end
  end

endmodule

module sleep_pd_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic sleep_stb,
  input logic exc_en,
  input logic stby_sel,
  input logic wake_irq,
  input logic pwr_down,
  input logic clk_en,
  input logic exc_req,
  input logic exc_cause,
  input logic cfg_err,
  input logic replay_q
);

  p_enter_r2: assert property (@(posedge clk) disable iff (rst)
    (sleep_stb && !exc_en && !wake_irq && !pwr_down && !replay_q) |=> (pwr_down && !exc_req));

  p_wake_r3: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && $rose(wake_irq)) |=> (!pwr_down && exc_req && !exc_cause));

  p_wake_clk_r4: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && $rose(wake_irq)) |-> clk_en);

  p_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && $past(pwr_down) && !$rose(wake_irq)) |-> !clk_en);

  p_sleep_exc_r5: assert property (@(posedge clk) disable iff (rst)
    (sleep_stb && exc_en && !pwr_down && !replay_q) |=> (exc_req && exc_cause && !pwr_down));

  p_cfg_set_r8: assert property (@(posedge clk) disable iff (rst)
    (sleep_stb && exc_en && stby_sel && !pwr_down && !replay_q) |=> cfg_err);

  p_cfg_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

endmodule

bind sleep_pd_ctrl sleep_pd_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .exc_en(exc_en),
  .stby_sel(stby_sel), .wake_irq(wake_irq), .pwr_down(pwr_down),
  .clk_en(clk_en), .exc_req(exc_req), .exc_cause(exc_cause),
  .cfg_err(cfg_err), .replay_q(replay_q)
);

// File: tb/sleep_pd_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_pd_ctrl_tb;

  logic clk = 1'b0;
  logic rst, sleep_stb, exc_en, stby_sel, wake_irq, rte_stb;
  logic pwr_down, clk_en, exc_req, exc_cause, cfg_err;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sleep_pd_ctrl u_dut (
    .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .exc_en(exc_en),
    .stby_sel(stby_sel), .wake_irq(wake_irq), .rte_stb(rte_stb),
    .pwr_down(pwr_down), .clk_en(clk_en), .exc_req(exc_req),
    .exc_cause(exc_cause), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    sleep_stb = 1'b0;
    rte_stb   = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; sleep_stb = 0; exc_en = 0; stby_sel = 0; wake_irq = 0; rte_stb = 0;
    @(negedge clk);
    do_reset();
    chk("R1 pwr_down", pwr_down, 1'b0);
    chk("R1 clk_en", clk_en, 1'b1);
    chk("R1 exc_req", exc_req, 1'b0);
    chk("R1 cfg_err", cfg_err, 1'b0);

    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 4; d++) begin
        stby_sel = s[0]; exc_en = 0; wake_irq = 0; sleep_stb = 1;
        step();
        chk("R2 pwr_down set", pwr_down, 1'b1);
        chk("R2 no exception", exc_req, 1'b0);
        chk("R4 clk_en first cycle", clk_en, 1'b1);
        for (int k = 0; k <= d; k++) begin
          step();
          chk("R4 clk_en gated", clk_en, 1'b0);
          chk("R2 stays down", pwr_down, 1'b1);
        end
        wake_irq = 1; #1;
        chk("R4 clk_en on wake", clk_en, 1'b1);
        step();
        chk("R3 pwr_down cleared", pwr_down, 1'b0);
        chk("R3 exc_req", exc_req, 1'b1);
        chk("R3 cause interrupt", exc_cause, 1'b0);
        wake_irq = 0;
        step();
        chk("R9 single pulse", exc_req, 1'b0);
      end
    end

    for (int w = 0; w < 2; w++) begin
      stby_sel = 0; exc_en = 1; wake_irq = w[0]; sleep_stb = 1;
      step();
      chk("R5 exc_req", exc_req, 1'b1);
      chk("R5 cause sleep", exc_cause, 1'b1);
      chk("R5 no power-down", pwr_down, 1'b0);
      chk("R8 cfg_err clear", cfg_err, 1'b0);
      rte_stb = 1;
      step();
      chk("R9 single pulse", exc_req, 1'b0);
      chk("R5 still running", pwr_down, 1'b0);
      step();
      chk("R10 rte ignored", pwr_down, 1'b0);
      chk("R4 clk_en running", clk_en, 1'b1);
      wake_irq = 0;
      step();
    end

    for (int g = 0; g < 3; g++) begin
      exc_en = 0; stby_sel = 0; wake_irq = 1; sleep_stb = 1;
      step();
      chk("R6 exc_req", exc_req, 1'b1);
      chk("R6 cause interrupt", exc_cause, 1'b0);
      chk("R6 not down yet", pwr_down, 1'b0);
      for (int k = 0; k < g; k++) begin
        step();
        chk("R6 waits for return", pwr_down, 1'b0);
        chk("R9 no repeat", exc_req, 1'b0);
      end
      rte_stb = 1;
      step();
      chk("R6 down after return", pwr_down, 1'b1);
      for (int k = 0; k < 3; k++) begin
        step();
        chk("R7 old level no wake", pwr_down, 1'b1);
        chk("R7 no exception", exc_req, 1'b0);
      end
      wake_irq = 0;
      step();
      chk("R7 still down", pwr_down, 1'b1);
      wake_irq = 1; #1;
      chk("R4 clk_en on new wake", clk_en, 1'b1);
      step();
      chk("R7 new edge wakes", pwr_down, 1'b0);
      chk("R3 exc_req after wake", exc_req, 1'b1);
      wake_irq = 0;
      step();
    end

    exc_en = 1; stby_sel = 1; sleep_stb = 1;
    step();
    chk("R8 cfg_err set", cfg_err, 1'b1);
    chk("R8 exception taken", exc_req, 1'b1);
    chk("R8 cause sleep", exc_cause, 1'b1);
    exc_en = 0; stby_sel = 0; sleep_stb = 1;
    step();
    chk("R8 sticky", cfg_err, 1'b1);
    chk("R2 down after cfg", pwr_down, 1'b1);
    do_reset();
    chk("R1 cfg_err cleared", cfg_err, 1'b0);
    chk("R1 pwr_down cleared", pwr_down, 1'b0);
    chk("R1 clk_en", clk_en, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule